// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Sequencer

This block brings an asynchronous page-mode DRAM out of power-up and then keeps its contents alive. After reset is released it keeps every strobe idle for a programmable pause. It then runs a burst of wake-up refresh cycles and only afterwards declares the device usable. From then on an interval timer adds one owed refresh every period, sized so that the full refresh count fits inside the retention window. Owed refreshes are paid back one by one whenever the strobes can be obtained.

Every refresh is of the CAS-before-RAS kind. CAS# goes low first, RAS# follows, and WE# stays high. The device's internal row counter supplies the address, so no address is driven here. The strobes are shared with an access arbiter through a request/grant pair. The sequencer raises `rfsh_req`, and a cycle begins on the first clock edge where `rfsh_gnt` is also high. Back-pressure is expressed only by withholding the grant. While the grant is low, `rfsh_req` stays up and no strobe moves. Once a cycle has started it runs to the end of its precharge whatever the grant does, and `rfsh_req` stays high throughout.

Owed refreshes are counted. If one more falls due while the count already sits at its limit, the deadline is treated as overrun. The sequencer then drops the ready flag, raises `overrun` and repeats the whole wake-up burst before resuming normal service.

Top module: `dram_rfsh_sched`

## Requirements
- R1: While reset is held, RAS#, CAS# and WE# are high, `rfsh_req`, `dev_ready` and `overrun` are low, and `acc_block` is high.
- R2: After reset release, no strobe moves and `rfsh_req` stays low for PAUSE_CYC = ceil(CLK_MHZ·PAUSE_NS/1000) clock cycles. The request appears on the cycle after that, or at most one cycle later.
- R3: After the pause, exactly WAKE_CYCLES refresh cycles are run, each waiting for its own grant. `dev_ready` rises only after the last of them has finished its precharge, with all strobes high.
- R4: In every refresh cycle CAS# goes low exactly CSR_CYC cycles before RAS# falls, and RAS# is low only while CAS# is low.
- R5: RAS# stays low for RAS_CYC cycles. Both strobes then stay high for at least PRE_CYC cycles before CAS# falls again.
- R6: WE# never goes low.
- R7: A cycle starts only on an edge where both `rfsh_req` and `rfsh_gnt` are high. CAS# falls one cycle after the grant is first seen. The request stays high while the grant is withheld and throughout a running cycle.
- R8: `dev_ready` is low and `acc_block` is high during the pause and during every wake-up burst. `acc_block` is low once `dev_ready` is high.
- R9: In normal service with the grant always given, one refresh cycle runs per INTERVAL_CYC = ceil(CLK_MHZ·INTERVAL_NS/1000) cycles.
- R10: Refreshes that fall due while the grant is withheld are remembered, up to PEND_LIMIT of them. When the grant returns they are all run back to back, without an overrun.
- R11: If a refresh falls due while PEND_LIMIT are already owed, `overrun` goes high and `dev_ready` drops. WAKE_CYCLES refresh cycles are then run, after which `overrun` clears and `dev_ready` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rfsh_gnt | input | 1 | Arbiter grants the strobes to the sequencer |
| rfsh_req | output | 1 | Sequencer asks for, or is holding, the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low (held high) |
| dev_ready | output | 1 | Initialization done, device usable |
| acc_block | output | 1 | Arbiter must hold off normal accesses |
| overrun | output | 1 | Refresh deadline missed, recovery burst running |

## Verification
The properties assume that the arbiter never drives the strobes itself while it grants them to the sequencer. They also assume that the grant is only a permission sampled at cycle start, so dropping it mid-cycle is legal. The strobe-shape properties also assume PRE_CYC of at least two and CSR_CYC of at least one, and the bench parameters respect both. The stimulus raises the grant only while a request is pending, at varied delays from the request. It withholds the grant for whole refresh periods, first just up to the pending limit and then past it, so that both the saturating and the overrun paths are reached.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [1:0] {
    ST_PAUSE = 2'd0,
    ST_WAKE  = 2'd1,
    ST_RUN   = 2'd2
  } init_st_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CSR  = 2'd1,
    PH_RAS  = 2'd2,
    PH_PRE  = 2'd3
  } cbr_ph_e;

  // Nanoseconds to clock cycles, rounded up.
  function automatic int ns2cyc(input int mhz, input int ns);
    return (mhz * ns + 999) / 1000;
  endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int INTERVAL_CYC = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int IW = $clog2(INTERVAL_CYC + 1);

  logic [IW-1:0] cnt;

  assign tick = en && (cnt == IW'(INTERVAL_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !en) cnt <= '0;
    else if (tick)     cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rfsh_pending_ctr.sv
module rfsh_pending_ctr #(
  parameter int PEND_LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  input  logic dec,
  output logic pend_nz,
  output logic ovf
);
  localparam int PW = $clog2(PEND_LIMIT + 2);

  logic [PW-1:0] cnt;

  assign pend_nz = (cnt != '0);
  assign ovf     = inc && !dec && (cnt == PW'(PEND_LIMIT));

  always_ff @(posedge clk) begin
    if (!rst_n || clr || ovf)        cnt <= '0;
    else if (inc && !dec)            cnt <= cnt + 1'b1;
    else if (dec && !inc && pend_nz) cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/cbr_strobe_seq.sv
module cbr_strobe_seq
  import dram_rfsh_pkg::*;
#(
  parameter int CSR_CYC = 2,
  parameter int RAS_CYC = 4,
  parameter int PRE_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  localparam int MAXC = (CSR_CYC > RAS_CYC) ?
                        ((CSR_CYC > PRE_CYC) ? CSR_CYC : PRE_CYC) :
                        ((RAS_CYC > PRE_CYC) ? RAS_CYC : PRE_CYC);
  localparam int CW = $clog2(MAXC + 1);

  cbr_ph_e       ph, ph_d;
  logic [CW-1:0] cnt, cnt_d;

  always_comb begin
    ph_d  = ph;
    cnt_d = cnt + 1'b1;
    done  = 1'b0;
    unique case (ph)
      PH_IDLE: begin
        cnt_d = '0;
        if (start) ph_d = PH_CSR;
      end
      PH_CSR: if (cnt == CW'(CSR_CYC - 1)) begin
        ph_d  = PH_RAS;
        cnt_d = '0;
      end
      PH_RAS: if (cnt == CW'(RAS_CYC - 1)) begin
        ph_d  = PH_PRE;
        cnt_d = '0;
      end
      PH_PRE: if (cnt == CW'(PRE_CYC - 1)) begin
        ph_d  = PH_IDLE;
        cnt_d = '0;
        done  = 1'b1;
      end
      default: begin
        ph_d  = PH_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  assign busy = (ph != PH_IDLE);
  assign we_n = 1'b1;

  // Strobes come straight from flops, decoded from the next phase.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph    <= PH_IDLE;
      cnt   <= '0;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
    end else begin
      ph    <= ph_d;
      cnt   <= cnt_d;
      ras_n <= !(ph_d == PH_RAS);
      cas_n <= !((ph_d == PH_CSR) || (ph_d == PH_RAS));
    end
  end
endmodule

// File: rtl/dram_rfsh_sched.sv
module dram_rfsh_sched
  import dram_rfsh_pkg::*;
#(
  parameter int CLK_MHZ     = 50,
  parameter int PAUSE_NS    = 100000,
  parameter int INTERVAL_NS = 15600,
  parameter int WAKE_CYCLES = 8,
  parameter int PEND_LIMIT  = 4,
  parameter int CSR_CYC     = 2,
  parameter int RAS_CYC     = 4,
  parameter int PRE_CYC     = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rfsh_gnt,
  output logic rfsh_req,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic dev_ready,
  output logic acc_block,
  output logic overrun
);
  localparam int PAUSE_CYC    = ns2cyc(CLK_MHZ, PAUSE_NS);
  localparam int INTERVAL_CYC = ns2cyc(CLK_MHZ, INTERVAL_NS);
  localparam int PCW          = $clog2(PAUSE_CYC + 1);
  localparam int WCW          = $clog2(WAKE_CYCLES + 1);

  init_st_e       st;
  logic [PCW-1:0] pause_cnt;
  logic [WCW-1:0] wake_cnt;
  logic           ovr_q;
  logic           busy, done, tick, pend_nz, ovf, want, start;

  assign want      = (st == ST_WAKE) || ((st == ST_RUN) && pend_nz);
  assign start     = want && rfsh_gnt && !busy;
  assign rfsh_req  = want || busy;
  assign dev_ready = (st == ST_RUN);
  assign acc_block = !dev_ready;
  assign overrun   = ovr_q;

  rfsh_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (st == ST_RUN),
    .tick (tick)
  );

  rfsh_pending_ctr #(.PEND_LIMIT(PEND_LIMIT)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (st != ST_RUN),
    .inc    (tick),
    .dec    (done && (st == ST_RUN)),
    .pend_nz(pend_nz),
    .ovf    (ovf)
  );

  cbr_strobe_seq #(
    .CSR_CYC(CSR_CYC),
    .RAS_CYC(RAS_CYC),
    .PRE_CYC(PRE_CYC)
  ) u_seq (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .busy (busy),
    .done (done),
    .ras_n(ras_n),
    .cas_n(cas_n),
    .we_n (we_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_PAUSE;
      pause_cnt <= '0;
      wake_cnt  <= '0;
      ovr_q     <= 1'b0;
    end else begin
      unique case (st)
        ST_PAUSE: begin
          if (pause_cnt == PCW'(PAUSE_CYC - 1)) begin
            st       <= ST_WAKE;
            wake_cnt <= '0;
          end else begin
            pause_cnt <= pause_cnt + 1'b1;
          end
        end
        ST_WAKE: if (done) begin
          if (wake_cnt == WCW'(WAKE_CYCLES - 1)) begin
            st    <= ST_RUN;
            ovr_q <= 1'b0;
          end else begin
            wake_cnt <= wake_cnt + 1'b1;
          end
        end
        ST_RUN: if (ovf) begin
          st       <= ST_WAKE;
          wake_cnt <= '0;
          ovr_q    <= 1'b1;
        end
        default: st <= ST_PAUSE;
      endcase
    end
  end
endmodule

// File: rtl/dram_rfsh_sched_chk.sv
module dram_rfsh_sched_chk (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic rfsh_req,
  input logic rfsh_gnt,
  input logic dev_ready,
  input logic overrun
);
  AST_RAS_UNDER_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !cas_n); // R4
  AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(!cas_n)); // R4
  AST_PRECHARGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |=> (ras_n && cas_n)); // R5
  AST_START_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> $past(rfsh_req && rfsh_gnt)); // R7
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> rfsh_req); // R7
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_ready) |-> (ras_n && cas_n)); // R3
  AST_OVR_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> !dev_ready); // R11
endmodule

bind dram_rfsh_sched dram_rfsh_sched_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ras_n    (ras_n),
  .cas_n    (cas_n),
  .rfsh_req (rfsh_req),
  .rfsh_gnt (rfsh_gnt),
  .dev_ready(dev_ready),
  .overrun  (overrun)
);

// File: tb/dram_rfsh_sched_bench.sv
module dram_rfsh_sched_bench;
  localparam int CLK_MHZ = 50, PAUSE_NS = 1000, INTERVAL_NS = 2000;
  localparam int WAKE = 8, LIM = 3, CSR = 2, RASC = 4, PRE = 3;
  localparam int PAUSE_CYC = (CLK_MHZ * PAUSE_NS + 999) / 1000;
  localparam int INT_CYC   = (CLK_MHZ * INTERVAL_NS + 999) / 1000;
  // {grant delay after the sequencer goes idle, expected cycles from grant to CAS# low}
  localparam int VEC [WAKE][2] = '{'{0,1},'{1,1},'{3,1},'{5,1},'{2,1},'{0,1},'{4,1},'{1,1}};

  logic clk = 1'b0, rst_n = 1'b0, gnt_en = 1'b0;
  logic rfsh_req, ras_n, cas_n, we_n, dev_ready, acc_block, overrun;
  wire  rfsh_gnt = gnt_en && rfsh_req;

  int n_run = 0, n_fail = 0;
  int ras_falls = 0, cas_falls = 0, we_low = 0;
  int cas_lo_run = 0, ras_lo_run = 0, idle_run = 0;
  bit prev_ras = 1'b1, prev_cas = 1'b1, seen_cycle = 1'b0, finished = 1'b0;

  always #10 clk = ~clk;

  dram_rfsh_sched #(
    .CLK_MHZ(CLK_MHZ), .PAUSE_NS(PAUSE_NS), .INTERVAL_NS(INTERVAL_NS),
    .WAKE_CYCLES(WAKE), .PEND_LIMIT(LIM), .CSR_CYC(CSR), .RAS_CYC(RASC), .PRE_CYC(PRE)
  ) u_dram_rfsh_sched (
    .clk(clk), .rst_n(rst_n), .rfsh_gnt(rfsh_gnt), .rfsh_req(rfsh_req),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .dev_ready(dev_ready),
    .acc_block(acc_block), .overrun(overrun)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // Strobe shape monitor, sampled on falling edges.
  always @(negedge clk) begin
    if (rst_n) begin
      if (!we_n) we_low++;
      if (prev_cas && !cas_n) begin
        cas_falls++;
        if (seen_cycle) chk(idle_run >= PRE, "R5 precharge length", idle_run, PRE);
      end
      if (prev_ras && !ras_n) begin
        ras_falls++;
        chk(cas_lo_run == CSR && !cas_n, "R4 CAS lead before RAS", cas_lo_run, CSR);
      end
      if (!prev_ras && ras_n) begin
        seen_cycle = 1'b1;
        chk(ras_lo_run == RASC, "R5 RAS low length", ras_lo_run, RASC);
      end
      if (!cas_n && ras_n) cas_lo_run++;
      else if (cas_n)      cas_lo_run = 0;
      ras_lo_run = ras_n ? 0 : ras_lo_run + 1;
      idle_run   = (ras_n && cas_n) ? idle_run + 1 : 0;
    end
    prev_ras = ras_n;
    prev_cas = cas_n;
  end

  initial begin
    repeat (20000) @(negedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int cnt, base;
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n, "R1 strobes idle in reset", {ras_n, cas_n, we_n}, 7);
    chk(!rfsh_req && !dev_ready && !overrun, "R1 outputs low in reset",
        {rfsh_req, dev_ready, overrun}, 0);
    chk(acc_block, "R1 access blocked in reset", acc_block, 1);

    rst_n = 1'b1;
    cnt = 0;
    while (!rfsh_req && cnt < 1000) begin @(negedge clk); cnt++; end
    chk(cnt >= PAUSE_CYC && cnt <= PAUSE_CYC + 1, "R2 pause length", cnt, PAUSE_CYC);
    chk(cas_falls == 0, "R2 no strobe during pause", cas_falls, 0);
    chk(!dev_ready && acc_block, "R8 not ready after pause", dev_ready, 0);

    // Wake-up burst, walked from the vector table.
    for (int i = 0; i < WAKE; i++) begin
      repeat (VEC[i][0]) @(negedge clk);
      chk(rfsh_req && cas_n, "R7 request waits for grant", {rfsh_req, cas_n}, 3);
      gnt_en = 1'b1;
      cnt = 0;
      do begin @(negedge clk); cnt++; end while (cas_n && cnt < 20);
      chk(cnt == VEC[i][1], "R7 grant to CAS latency", cnt, VEC[i][1]);
      gnt_en = 1'b0;
      while (ras_n)  @(negedge clk);
      while (!ras_n) @(negedge clk);
      repeat (PRE) @(negedge clk);
      if (i < WAKE - 1) chk(!dev_ready && acc_block, "R8 not ready mid burst", dev_ready, 0);
      else              chk(dev_ready && !acc_block, "R3 ready after burst", dev_ready, 1);
    end
    chk(ras_falls == WAKE, "R3 wake cycle count", ras_falls, WAKE);

    // Steady service with the grant always given.
    gnt_en = 1'b1;
    base = ras_falls;
    repeat (10 * INT_CYC + 20) @(negedge clk);
    chk(ras_falls - base == 10, "R9 refresh rate", ras_falls - base, 10);

    // Withhold the grant for exactly the pending limit.
    while (ras_n) @(negedge clk);
    gnt_en = 1'b0;
    repeat (3 * INT_CYC + 20) @(negedge clk);
    chk(!overrun && dev_ready && rfsh_req, "R10 owed refreshes held",
        {overrun, dev_ready, rfsh_req}, 3);
    base = ras_falls;
    gnt_en = 1'b1;
    repeat (40) @(negedge clk);
    chk(ras_falls - base == LIM, "R10 back-to-back payback", ras_falls - base, LIM);
    chk(!overrun, "R10 no overrun at limit", overrun, 0);

    // Withhold past the limit.
    gnt_en = 1'b0;
    repeat (4 * INT_CYC + 10) @(negedge clk);
    chk(overrun && !dev_ready, "R11 overrun drops ready", {overrun, dev_ready}, 2);
    chk(acc_block, "R8 blocked during recovery", acc_block, 1);
    base = ras_falls;
    gnt_en = 1'b1;
    cnt = 0;
    while (!dev_ready && cnt < 500) begin @(negedge clk); cnt++; end
    chk(ras_falls - base == WAKE, "R11 recovery burst count", ras_falls - base, WAKE);
    chk(!overrun && dev_ready, "R11 overrun cleared", {overrun, dev_ready}, 1);

    chk(we_low == 0, "R6 WE# never low", we_low, 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule